// File: doc/BRIEF.md
# Indirect-Address MDIO Command Engine

This block is a management-bus master for PHY devices that use indirect register addressing. Software programs a 32-bit command register with a 16-bit register address, a 5-bit device type, a 5-bit port address, a 2-bit operation code and a go bit. The block then sends one complete 64-bit management frame on MDC/MDIO. When the last bit has been clocked out, the block clears the go bit by itself, and software can poll for that.

A full PHY access takes two commands. The first is an address cycle that sets up the register pointer inside the PHY. The second is a write or a read. For a write, software first places the 16-bit value in the low half of the data register. For a read, the returned value arrives in the upper half of that register, so software shifts it down before use. MDC comes from a fixed divider of the system clock. Commands whose fields are out of range are refused.

Top module: `mdio_ind_master`

## Requirements
- R1: After reset, `cmd_q` and `data_q` read zero, `mdc` is low, `mdio_oe` is low and `mdio_o` is high.
- R2: A write with `reg_sel`=0 is accepted only when it sets bit 30 (go), clears bits 31, 29 and 28, and the block is idle. Field layout: [15:0] register address, [20:16] device type, [25:21] port address, [27:26] opcode. Once accepted, `cmd_q` returns those fields with bit 30 set until the frame ends.
- R3: Each frame is driven MSB first, with bit i held for one MDC period. It consists of PRE_LEN ones, start 00, the opcode, the port (5 bits), the device type (5 bits), turnaround 10, and 16 payload bits. For opcode 00 (address) the payload is the register address field.
- R4: For opcode 01 (write), the payload is `data_q[15:0]` as it stood when the command was accepted.
- R5: For opcode 11 (read), `mdio_oe` falls at the first turnaround bit and stays low to the end of the frame. The 16 bits on `mdio_i` are taken at the rising MDC edges of the payload bits, MSB first, and are written to `data_q[31:16]` when the frame ends. `data_q[15:0]` is left unchanged.
- R6: MDC starts low and toggles every HALF_DIV clocks while a frame runs. The go bit clears on the final falling MDC edge, exactly (PRE_LEN+32)*2*HALF_DIV clocks after acceptance. MDC is low whenever the engine is idle.
- R7: Command writes that arrive while the go bit is set are ignored, and the running frame and `cmd_q` are not affected.
- R8: A command whose port exceeds MAX_PORT, whose device type exceeds MAX_DEV, whose register address exceeds MAX_REG, or whose opcode is 10 is ignored. The engine stays idle.
- R9: A write with `reg_sel`=1 loads all 32 bits of `data_q` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command register, 1 = data register |
| reg_wdata | input | 32 | Write data |
| cmd_q | output | 32 | Command register readback, bit 30 = go/busy |
| data_q | output | 32 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value (high when released) |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions assume that the PHY holds `mdio_i` stable across each rising MDC edge of a read payload. They also assume that software never writes the data register in the same clock as a read completes, because the upper half would then have two sources. The stimulus changes `mdio_i` only at the start of each bit period and issues data writes only while the engine is idle. Even so, it includes command writes during a busy frame and commands with out-of-range fields. A behavioural model in the bench predicts MDC, MDIO, enable and both registers on every clock.

// File: rtl/mdio_ind_pkg.sv
package mdio_ind_pkg;
   typedef enum logic [1:0] {
      OP_ADDR  = 2'b00,
      OP_WRITE = 2'b01,
      OP_RSVD  = 2'b10,
      OP_READ  = 2'b11
   } mdio_op_e;

   localparam int ADR_W    = 16;
   localparam int FLD_W    = 5;
   localparam int REG_LSB  = 0;
   localparam int DEV_LSB  = 16;
   localparam int PORT_LSB = 21;
   localparam int OP_LSB   = 26;
   localparam int GO_BIT   = 30;
endpackage

// File: rtl/mdio_ind_mdc.sv
module mdio_ind_mdc #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic fall_evt
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] WRAP = CW'(HALF_DIV - 1);

   if (HALF_DIV < 2) begin : g_bad_div
      $error("HALF_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          mdc_q;
   logic          at_wrap;

   assign at_wrap  = (cnt == WRAP);
   assign rise_evt = run & at_wrap & ~mdc_q;
   assign fall_evt = run & at_wrap & mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (run) begin
         cnt <= at_wrap ? '0 : cnt + 1'b1;
         if (at_wrap) mdc_q <= ~mdc_q;
      end
   end

   // R6: between frames the divider rests low with a cleared counter
   p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!mdc_q && cnt == '0));
endmodule

// File: rtl/mdio_ind_frame.sv
module mdio_ind_frame #(
   parameter int PRE_LEN = 32,
   parameter bit IN_SYNC = 1'b1,
   localparam int FL     = PRE_LEN + 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [FL-1:0] load_frame,
   input  logic          load_rd,
   input  logic          rise_evt,
   input  logic          fall_evt,
   input  logic          mdio_i,
   output logic          busy,
   output logic          mdio_o,
   output logic          mdio_oe,
   output logic [15:0]   rd_data,
   output logic          rd_done
);
   localparam int IW = $clog2(FL);
   localparam logic [IW-1:0] LAST    = IW'(FL - 1);
   localparam logic [IW-1:0] TA_POS  = IW'(PRE_LEN + 14);
   localparam logic [IW-1:0] DAT_POS = IW'(PRE_LEN + 16);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end

   logic          mdio_s;
   logic [FL-1:0] sh;
   logic [IW-1:0] idx;
   logic          is_rd;
   logic [15:0]   rd_sh;

   if (IN_SYNC) begin : g_sync
      logic sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= 1'b1;
         else        sync_q <= mdio_i;
      end
      assign mdio_s = sync_q;
   end else begin : g_direct
      assign mdio_s = mdio_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh    <= '0;
         idx   <= '0;
         busy  <= 1'b0;
         is_rd <= 1'b0;
         rd_sh <= '0;
      end else if (load) begin
         sh    <= load_frame;
         idx   <= '0;
         busy  <= 1'b1;
         is_rd <= load_rd;
      end else if (busy) begin
         if (rise_evt && is_rd && idx >= DAT_POS) rd_sh <= {rd_sh[14:0], mdio_s};
         if (fall_evt) begin
            sh  <= {sh[FL-2:0], 1'b1};
            idx <= idx + 1'b1;
            if (idx == LAST) busy <= 1'b0;
         end
      end
   end

   assign mdio_oe = busy & ~(is_rd & (idx >= TA_POS));
   assign mdio_o  = mdio_oe ? sh[FL-1] : 1'b1;
   assign rd_data = rd_sh;
   assign rd_done = busy & fall_evt & is_rd & (idx == LAST);

   // R1: the pad is released and pulled high whenever no frame runs
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && mdio_o));
   // R5: once released inside a frame, MDIO is not driven again before the frame ends
   p_no_redrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_ind_master.sv
module mdio_ind_master
   import mdio_ind_pkg::*;
#(
   parameter int          HALF_DIV = 4,
   parameter int          PRE_LEN  = 32,
   parameter bit          IN_SYNC  = 1'b1,
   parameter int unsigned MAX_REG  = 65535,
   parameter int unsigned MAX_PORT = 31,
   parameter int unsigned MAX_DEV  = 31
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] cmd_q,
   output logic [31:0] data_q,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int FL = PRE_LEN + 32;

   if (MAX_PORT > 31 || MAX_DEV > 31 || MAX_REG > 65535) begin : g_bad_max
      $error("field limits exceed field widths");
   end

   logic [ADR_W-1:0] w_reg;
   logic [FLD_W-1:0] w_dev, w_port;
   mdio_op_e         w_op;
   logic             fields_ok, cmd_ok;

   logic [ADR_W-1:0] reg_q;
   logic [FLD_W-1:0] dev_q, port_q;
   mdio_op_e         op_q;
   logic [31:0]      data_r;
   logic [FL-1:0]    frame;
   logic [15:0]      payload;
   logic             busy, rise_evt, fall_evt, rd_done;
   logic [15:0]      rd_data;

   assign w_reg  = reg_wdata[REG_LSB +: ADR_W];
   assign w_dev  = reg_wdata[DEV_LSB +: FLD_W];
   assign w_port = reg_wdata[PORT_LSB +: FLD_W];
   assign w_op   = mdio_op_e'(reg_wdata[OP_LSB +: 2]);

   assign fields_ok = reg_wdata[GO_BIT] & ~reg_wdata[31] & ~|reg_wdata[29:28]
                    & (w_op != OP_RSVD)
                    & (32'(w_port) <= MAX_PORT) & (32'(w_dev) <= MAX_DEV)
                    & (32'(w_reg) <= MAX_REG);
   assign cmd_ok = reg_wr & ~reg_sel & ~busy & fields_ok;

   always_comb begin
      case (w_op)
         OP_ADDR:  payload = w_reg;
         OP_WRITE: payload = data_r[15:0];
         default:  payload = 16'hFFFF;
      endcase
      frame = {{PRE_LEN{1'b1}}, 2'b00, w_op, w_port, w_dev, 2'b10, payload};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q  <= '0;
         dev_q  <= '0;
         port_q <= '0;
         op_q   <= OP_ADDR;
      end else if (cmd_ok) begin
         reg_q  <= w_reg;
         dev_q  <= w_dev;
         port_q <= w_port;
         op_q   <= w_op;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_r <= '0;
      end else begin
         if (reg_wr && reg_sel) data_r <= reg_wdata;
         if (rd_done)           data_r[31:16] <= rd_data;
      end
   end

   mdio_ind_mdc #(.HALF_DIV(HALF_DIV)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_ind_frame #(.PRE_LEN(PRE_LEN), .IN_SYNC(IN_SYNC)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cmd_ok),
      .load_frame (frame),
      .load_rd    (w_op == OP_READ),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .mdio_i     (mdio_i),
      .busy       (busy),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .rd_data    (rd_data),
      .rd_done    (rd_done)
   );

   assign cmd_q  = {1'b0, busy, 2'b00, op_q, port_q, dev_q, reg_q};
   assign data_q = data_r;

   // R2: a frame only starts from a command-register write
   p_start_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && !reg_sel));
   // R7: stored fields hold while a frame runs
   p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cmd_q[27:0]));
   // R8: an out-of-range port never starts a frame
   p_reject_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && !busy && 32'(w_port) > MAX_PORT) |=> !busy);
   // R6: the go bit clears with MDC low
   p_end_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !mdc);
   // R5: the read half changes only at frame end or by a data write
   p_rdhalf_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_q[31:16]) |-> ($fell(busy) || $past(reg_wr && reg_sel)));
endmodule

// File: tb/sim_mdio_ind_master.sv
module sim_mdio_ind_master;
   localparam int H      = 2;
   localparam int MPORT  = 20;
   localparam int MDEV   = 30;
   localparam int FLEN   = 64;
   localparam int FCYC   = FLEN * 2 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        mdio_i = 1'b1;
   logic [31:0] cmd_q, data_q;
   logic        mdc, mdio_o, mdio_oe;

   always #2 clk = ~clk;

   mdio_ind_master #(.HALF_DIV(H), .PRE_LEN(32), .IN_SYNC(1'b1),
                     .MAX_REG(65535), .MAX_PORT(MPORT), .MAX_DEV(MDEV)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .cmd_q(cmd_q), .data_q(data_q), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference model
   bit          m_active = 0;
   int          m_t = 0;
   int          m_op = 0, m_port = 0, m_dev = 0, m_reg = 0;
   logic [31:0] m_data = '0;
   logic [63:0] m_frame = '0;
   logic [15:0] rd_val = 16'h0000;

   function automatic bit cmd_valid(input logic [31:0] w);
      return w[30] && !w[31] && w[29:28] == 2'b00 && w[27:26] != 2'b10 &&
             int'(w[25:21]) <= MPORT && int'(w[20:16]) <= MDEV;
   endfunction

   function automatic logic [31:0] mk(input int op, input int port, input int dev, input int ra);
      return (32'(1) << 30) | (32'(op) << 26) | (32'(port) << 21) | (32'(dev) << 16) | 32'(ra[15:0]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_t = 0; m_op = 0; m_port = 0; m_dev = 0; m_reg = 0; m_data = '0;
      end else begin
         if (reg_wr && reg_sel) m_data = reg_wdata;
         if (m_active) begin
            m_t++;
            if (m_t == FCYC) begin
               m_active = 0;
               if (m_op == 3) m_data[31:16] = rd_val;
            end
         end else if (reg_wr && !reg_sel && cmd_valid(reg_wdata)) begin
            logic [15:0] pl;
            m_active = 1; m_t = 0;
            m_op = int'(reg_wdata[27:26]); m_port = int'(reg_wdata[25:21]);
            m_dev = int'(reg_wdata[20:16]); m_reg = int'(reg_wdata[15:0]);
            pl = (m_op == 0) ? reg_wdata[15:0] : (m_op == 1) ? m_data[15:0] : 16'hFFFF;
            m_frame = {32'hFFFF_FFFF, 2'b00, reg_wdata[27:26], reg_wdata[25:21],
                       reg_wdata[20:16], 2'b10, pl};
         end
      end
   end

   // per-clock comparison and PHY side
   always @(negedge clk) begin
      if (rst_n) begin
         int idx;
         bit e_mdc, e_oe;
         logic [31:0] e_cmd;
         idx   = m_t / (2 * H);
         e_mdc = m_active && ((m_t / H) % 2 == 1);
         e_oe  = m_active && !(m_op == 3 && idx >= 46);
         e_cmd = {1'b0, m_active, 2'b00, 2'(m_op), 5'(m_port), 5'(m_dev), 16'(m_reg)};
         chk(mdc == e_mdc, "R6", "mdc", 64'(mdc), 64'(e_mdc));
         chk(mdio_oe == e_oe, "R5", "mdio_oe", 64'(mdio_oe), 64'(e_oe));
         if (e_oe) chk(mdio_o == m_frame[63-idx], "R3", "mdio_o", 64'(mdio_o), 64'(m_frame[63-idx]));
         else      chk(mdio_o == 1'b1, "R1", "released mdio_o", 64'(mdio_o), 64'd1);
         chk(cmd_q == e_cmd, "R2", "cmd_q", 64'(cmd_q), 64'(e_cmd));
         chk(data_q == m_data, "R9", "data_q", 64'(data_q), 64'(m_data));
         mdio_i <= (m_active && m_op == 3 && idx >= 48) ? rd_val[63-idx] : 1'b1;
      end
   end

   logic [63:0] cap = '0;
   always @(posedge mdc) cap <= {cap[62:0], mdio_o};

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic run_cmd(input logic [31:0] c, output int cyc);
      wr(1'b0, c);
      cyc = 0;
      while (cmd_q[30]) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int cyc;
      logic [31:0] snap;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_q == 0 && data_q == 0 && !mdc && !mdio_oe && mdio_o, "R1", "reset state",
          {cmd_q, data_q}, 64'd0);

      // R9 data write, then R3 address cycle
      wr(1'b1, 32'h0000_A5C3);
      chk(data_q == 32'h0000_A5C3, "R9", "data load", 64'(data_q), 64'h0000_A5C3);
      run_cmd(mk(0, 3, 1, 16'h1234), cyc);
      chk(cyc == FCYC, "R6", "address frame length", 64'(cyc), 64'(FCYC));
      chk(cap == {32'hFFFF_FFFF, 2'b00, 2'b00, 5'd3, 5'd1, 2'b10, 16'h1234}, "R3",
          "address frame bits", cap, {32'hFFFF_FFFF, 2'b00, 2'b00, 5'd3, 5'd1, 2'b10, 16'h1234});

      // R4 write cycle with a busy-time command write (R7)
      wr(1'b0, mk(1, 3, 1, 16'h1234));
      repeat (40) @(negedge clk);
      snap = cmd_q;
      wr(1'b0, mk(3, 7, 2, 16'h0042));
      chk(cmd_q == snap, "R7", "cmd ignored while busy", 64'(cmd_q), 64'(snap));
      while (cmd_q[30]) @(negedge clk);
      chk(cap[15:0] == 16'hA5C3, "R4", "write payload", 64'(cap[15:0]), 64'hA5C3);
      chk(cap[63:16] == {32'hFFFF_FFFF, 2'b00, 2'b01, 5'd3, 5'd1, 2'b10}, "R3",
          "write header", 64'(cap[63:16]), 64'({32'hFFFF_FFFF, 2'b00, 2'b01, 5'd3, 5'd1, 2'b10}));

      // R5 read
      rd_val = 16'hBEEF;
      run_cmd(mk(0, 20, 30, 16'h0008), cyc);
      run_cmd(mk(3, 20, 30, 16'h0008), cyc);
      chk(cyc == FCYC, "R6", "read frame length", 64'(cyc), 64'(FCYC));
      chk(data_q == 32'hBEEF_A5C3, "R5", "read result in upper half", 64'(data_q), 64'hBEEF_A5C3);

      // R8 rejections
      wr(1'b0, mk(0, 21, 1, 16'h0001));
      @(negedge clk);
      chk(!cmd_q[30] && !mdc, "R8", "port above limit", 64'(cmd_q), 64'(0));
      wr(1'b0, mk(0, 1, 31, 16'h0001));
      chk(!cmd_q[30], "R8", "device above limit", 64'(cmd_q[30]), 64'd0);
      wr(1'b0, mk(2, 1, 1, 16'h0001));
      chk(!cmd_q[30], "R8", "reserved opcode", 64'(cmd_q[30]), 64'd0);
      wr(1'b0, 32'h0002_0001);
      chk(!cmd_q[30] && !mdio_oe, "R2", "go bit clear", 64'(cmd_q), 64'(0));

      // R5 second read pattern, low half preserved
      wr(1'b1, 32'h0000_0F0F);
      rd_val = 16'h8001;
      run_cmd(mk(3, 0, 0, 16'h0000), cyc);
      chk(data_q == 32'h8001_0F0F, "R5", "second read", 64'(data_q), 64'h8001_0F0F);

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule